// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Unit

This block sits beside an I2C master engine and lets it share the bus with other masters. It produces the local SCL waveform from a programmable half-period. Because SCL is a wired-AND line, the block adapts to the other masters on the bus. A low phase lasts until every master has released the line. A high phase ends as soon as any master pulls the line low. The block also watches SDA. When the engine wants a 1 on the bus but a 0 is seen while SCL is high, the block loses arbitration.

On a loss the block lets go of both lines on the next clock edge and gives up ownership without producing any STOP sequence. It sends a one-cycle strobe to the slave-receive path, which then serves the rest of the transfer if that transfer is addressed to this node. The block also sets a sticky lost flag. The flag stays set until a write-one-to-clear pulse arrives, and while it is set, new start requests are ignored.

The bus inputs pass through a two-stage synchroniser. Both line outputs are open-drain enables, where 1 pulls the line low and 0 releases it.

Top module: `i2c_arb_unit`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, arb_lost and to_slave are all 0.
- R2: A start_req pulse while arb_lost is 0 sets busy on the next clock edge. The SCL waveform then begins with a released (high) phase.
- R3: With no other master on the bus, scl_oe is held at 1 for exactly half_period cycles. It is then held at 0 for exactly half_period+3 cycles, where 3 cycles are the synchroniser and observation latency.
- R4: If another master keeps SCL low for X cycles after this block releases it, the released phase grows to X+half_period+3 cycles. The slowest low phase sets the bus low time.
- R5: If another master pulls SCL low Y cycles after release (1 <= Y < half_period), scl_oe returns to 1 after exactly Y+3 released cycles. The shortest high phase sets the bus high time.
- R6: SDA is compared only once per high phase, in the high-phase count cycle equal to sample_dly. Arbitration is lost when sda_tx is 1 and the synchronised SDA is 0 at that point. arb_lost then rises sample_dly+5 cycles after the first released SCL cycle. A low SDA seen earlier in the high phase is ignored, and with sda_tx at 0 the block never loses.
- R7: In the cycle arb_lost rises, busy, scl_oe and sda_oe are all 0. They stay 0 until a new accepted start, so no STOP and no further clock edges are driven.
- R8: to_slave is a single-cycle pulse that coincides with the rising edge of arb_lost.
- R9: arb_lost stays set until a lost_clr pulse. If a new loss and lost_clr occur in the same cycle, the loss wins.
- R10: start_req is refused while arb_lost is 1, and busy stays 0.
- R11: While busy, sda_oe equals the inverse of sda_tx, so SDA is only ever pulled low or released.
- R12: A done_req pulse clears busy on the next edge and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| start_req | input | 1 | Pulse: take bus ownership and start clocking |
| done_req | input | 1 | Pulse: give up bus ownership |
| sda_tx | input | 1 | Bit the engine wants on SDA (1 = release) |
| lost_clr | input | 1 | Write-one-to-clear for arb_lost |
| half_period | input | DIV_W | System cycles per local SCL low or high phase |
| sample_dly | input | DIV_W | High-phase count at which SDA is compared |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Block currently owns the bus as master |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| to_slave | output | 1 | One-cycle strobe handing the transfer to slave receive |

## Verification
The hardest case to reach from the ports is an SDA conflict that falls exactly on the comparison cycle of a high phase. The bench must also show that a conflict just before that cycle is ignored. To get there, the bench models a second master on both wired-AND lines and times its actions from the cycle in which this block's scl_oe falls. It holds SDA low either through the whole high phase or only through its first sample_dly cycles. The same model stretches and shortens SCL by chosen amounts, with random half-periods and stretch lengths from a fixed seed.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic active;
        logic lost;
        logic strobe;
    } ctl_t;
endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        logic [STAGES-1:0] sh_d;
        always_comb sh_d = {sh_q[STAGES-2:0], d[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end
        assign q[i] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_arb_sclgen.sv
module i2c_arb_sclgen
    import i2c_arb_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_s,
    input  logic [DIV_W-1:0] half_period,
    input  logic [DIV_W-1:0] sample_dly,
    output logic             scl_drive,
    output logic             sample_pt
);
    typedef struct packed {
        phase_e           ph;
        logic [DIV_W-1:0] cnt;
    } gen_t;

    gen_t             st_q, st_d;
    logic [DIV_W-1:0] last_cnt;

    assign last_cnt = half_period - 1'b1;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                st_d.ph  = PH_WAIT;
                st_d.cnt = '0;
            end
            PH_LOW: begin
                if (st_q.cnt == last_cnt) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (scl_s) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end
            end
            PH_HIGH: begin
                if (!scl_s || st_q.cnt == last_cnt) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '{ph: PH_IDLE, cnt: '0};
        endcase
        if (!run) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign scl_drive = (st_q.ph == PH_LOW);
    assign sample_pt = (st_q.ph == PH_HIGH) && scl_s && (st_q.cnt == sample_dly);
endmodule

// File: rtl/i2c_arb_unit.sv
module i2c_arb_unit
    import i2c_arb_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             start_req,
    input  logic             done_req,
    input  logic             sda_tx,
    input  logic             lost_clr,
    input  logic [DIV_W-1:0] half_period,
    input  logic [DIV_W-1:0] sample_dly,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             arb_lost,
    output logic             to_slave
);
    localparam int BUS_W = 2;

    logic [BUS_W-1:0] bus_s;
    logic             scl_s, sda_s;
    logic             scl_drive, sample_pt;
    logic             lose;
    ctl_t             ctl_q, ctl_d;

    i2c_arb_sync #(.W(BUS_W), .STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2c_arb_sclgen #(.DIV_W(DIV_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctl_q.active),
        .scl_s       (scl_s),
        .half_period (half_period),
        .sample_dly  (sample_dly),
        .scl_drive   (scl_drive),
        .sample_pt   (sample_pt)
    );

    // a released SDA that reads back low at the sample point means another master won
    assign lose = ctl_q.active && sample_pt && sda_tx && !sda_s;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.strobe = 1'b0;
        if (start_req && !ctl_q.lost && !ctl_q.active) ctl_d.active = 1'b1;
        if (done_req)                                  ctl_d.active = 1'b0;
        if (lost_clr)                                  ctl_d.lost   = 1'b0;
        if (lose) begin
            ctl_d.active = 1'b0;
            ctl_d.lost   = 1'b1;
            ctl_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign scl_oe   = ctl_q.active && scl_drive;
    assign sda_oe   = ctl_q.active && !sda_tx;
    assign busy     = ctl_q.active;
    assign arb_lost = ctl_q.lost;
    assign to_slave = ctl_q.strobe;
endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic lost_clr,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic arb_lost,
    input logic to_slave
);
    a_r7_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!busy && !scl_oe && !sda_oe));

    a_r8_strobe_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        to_slave |-> $rose(arb_lost));

    a_r8_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> to_slave);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        to_slave |=> !to_slave);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !lost_clr) |=> arb_lost);

    a_r10_start_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !busy && start_req) |=> !busy);

    a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_arb_unit i2c_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .lost_clr  (lost_clr),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .arb_lost  (arb_lost),
    .to_slave  (to_slave)
);

// File: tb/i2c_arb_unit_tb.sv
`timescale 1ns/1ps
module i2c_arb_unit_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_req = 1'b0, done_req = 1'b0, sda_tx = 1'b1, lost_clr = 1'b0;
    logic [DIV_W-1:0] half_period = 8'd10, sample_dly = 8'd2;
    logic             ext_scl = 1'b0, ext_sda = 1'b0;
    logic             scl_oe, sda_oe, busy, arb_lost, to_slave;
    logic             scl_in, sda_in;
    int               nvec = 0, nfail = 0, ncyc = 0;

    always #10 clk = ~clk;

    assign scl_in = !(scl_oe || ext_scl);
    assign sda_in = !(sda_oe || ext_sda);

    i2c_arb_unit #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .start_req(start_req), .done_req(done_req), .sda_tx(sda_tx), .lost_clr(lost_clr),
        .half_period(half_period), .sample_dly(sample_dly),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .arb_lost(arb_lost), .to_slave(to_slave)
    );

    function automatic int exp_low(int h);           return h; endfunction
    function automatic int exp_high(int h, int x);   return h + 3 + x; endfunction
    function automatic int exp_short(int y);         return y + 3; endfunction
    function automatic int exp_lost_at(int d);       return d + 5; endfunction

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; @(negedge clk); s = 1'b0;
    endtask

    task automatic measure_low(output int n);
        while (!scl_oe) @(negedge clk);
        n = 0;
        while (scl_oe) begin n++; @(negedge clk); end
    endtask

    // released phase; other master stretches by x, or cuts short after y (y>0)
    task automatic measure_high(input int x, input int y, output int n);
        while (scl_oe) @(negedge clk);
        n = 0;
        while (!scl_oe) begin
            n++;
            ext_scl = (n <= x) || (y > 0 && n > y);
            @(negedge clk);
        end
        ext_scl = 1'b0;
    endtask

    task automatic restart(input int h);
        pulse(done_req);
        half_period = DIV_W'(h);
        pulse(start_req);
    endtask

    initial begin
        int n, h, x;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {scl_oe, sda_oe, busy, arb_lost, to_slave}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse(start_req);
        chk("R2 busy after start", busy, 1);
        chk("R2 begins released", scl_oe, 0);
        measure_low(n);
        chk("R3 solo low", n, exp_low(10));
        measure_high(0, 0, n);
        chk("R3 solo high", n, exp_high(10, 0));
        measure_high(7, 0, n);
        chk("R4 stretched high", n, exp_high(10, 7));
        measure_high(0, 3, n);
        chk("R5 shortened high", n, exp_short(3));
        // random half-periods and stretches
        for (int i = 0; i < 8; i++) begin
            h = 4 + int'($urandom_range(8));
            x = int'($urandom_range(9));
            restart(h);
            measure_low(n);
            chk("R3 random low", n, exp_low(h));
            measure_high(x, 0, n);
            chk("R4 random high", n, exp_high(h, x));
        end
        restart(10);
        // R11 driving a 0: SDA pulled, conflict impossible
        measure_low(n);
        sda_tx = 1'b0; ext_sda = 1'b1;
        @(negedge clk);
        chk("R11 sda_oe for a zero", sda_oe, 1);
        measure_high(0, 0, n);
        chk("R6 no loss when sending zero", arb_lost, 0);
        ext_sda = 1'b0; sda_tx = 1'b1;
        @(negedge clk);
        chk("R11 sda released for a one", sda_oe, 0);
        // R6 early SDA glitch ignored
        while (!scl_oe) @(negedge clk);
        while (scl_oe) @(negedge clk);
        n = 0;
        while (!scl_oe) begin
            n++;
            ext_sda = (n <= int'(sample_dly));
            @(negedge clk);
        end
        ext_sda = 1'b0;
        chk("R6 early glitch ignored", arb_lost, 0);
        chk("R6 still busy", busy, 1);
        // R6 real loss
        while (!scl_oe) @(negedge clk);
        ext_sda = 1'b1;
        while (scl_oe) @(negedge clk);
        n = 1;
        while (!arb_lost && n < 100) begin @(negedge clk); n++; end
        chk("R6 loss timing", n, exp_lost_at(int'(sample_dly)));
        chk("R8 strobe with flag", to_slave, 1);
        chk("R7 busy cleared", busy, 0);
        @(negedge clk);
        chk("R8 strobe single cycle", to_slave, 0);
        ext_sda = 1'b0;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (scl_oe || sda_oe || busy) n++;
            @(negedge clk);
        end
        chk("R7 lines stay released", n, 0);
        chk("R9 flag sticky", arb_lost, 1);
        pulse(start_req);
        chk("R10 start refused", busy, 0);
        chk("R10 no clock", scl_oe, 0);
        pulse(lost_clr);
        chk("R9 cleared", arb_lost, 0);
        pulse(start_req);
        chk("R2 start after clear", busy, 1);
        measure_low(n);
        chk("R3 low after clear", n, exp_low(10));
        sda_tx = 1'b0;
        pulse(done_req);
        chk("R12 busy off", busy, 0);
        chk("R12 sda released", sda_oe, 0);
        chk("R12 scl released", scl_oe, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 100000) begin
            nvec++; nfail++;
            $display("FAIL watchdog: got %0d expected %0d", ncyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule